// File: doc/BRIEF.md
# DMA channel service engine

This block chooses which of several DMA channels is served in each clock cycle and keeps account of how far each channel has got through its programmed block. Every cycle the engine looks at all channels. It picks the lowest-numbered one that is unmasked, is requesting, has not finished its block and is not being reprogrammed in that cycle. It then performs one transfer unit for that channel. A unit is one byte, or a two-byte word when the width shift is 1. For the granted unit the engine reports the byte address, the address direction, the transfer type and the auto-reload flag. When the unit completes the block, it also raises a terminal-count strobe.

The surrounding controller provides the per-channel base counts, base addresses and mode bytes, the mask and request vectors, a global disable and the width shift. It pulses a per-channel load input whenever a channel is reprogrammed. Bus timing and the movement of data are handled outside this block.

Top module: `dma_svc_engine`

## Requirements
- R1: A channel is granted only when it is unmasked (mask bit 0), requesting (request bit 1) and has not finished its block. The grant vector `gnt_o` is registered, so it reflects the inputs of the previous cycle.
- R2: At most one grant is given per cycle. When several channels are eligible, the lowest-numbered one wins.
- R3: Each grant comes with an `inc_o` pulse in the same cycle and advances that channel's transferred byte count by `1 << shift_i`.
- R4: The block length in bytes is `(base_count + 1) << shift_i`. When a grant brings the count exactly to that length, the engine pulses that channel's bit of `tc_o` together with the grant, and it sets the sticky bit `tc_stat_o` for that channel.
- R5: The byte address of a granted unit is `(base_addr << shift_i)` plus the count before the unit, or minus that count when mode bit 5 is 1, taken modulo 2^(CNT_W+2). `dir_down_o` shows mode bit 5.
- R6: With each grant, `xfer_type_o` shows mode bits [3:2] and `autoinit_o` shows mode bit 4 of the granted channel. While no channel is granted, the address, direction, type and auto-reload outputs are 0.
- R7: After terminal count with mode bit 4 clear, the channel is not granted again until it is loaded. With mode bit 4 set, its count returns to 0 and it keeps being served.
- R8: While `ctl_dis_i` is 1, no channel is granted and no channel's count changes.
- R9: A `load_i` pulse clears that channel's count, finished state and `tc_stat_o` bit. In the load cycle that channel is not granted, so the grant passes to the next eligible channel.
- R10: While `rst` is held and in the first cycle after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_dis_i | input | 1 | Global disable of granting |
| shift_i | input | 1 | Width shift: 0 byte units, 1 word units |
| mask_i | input | NUM_CH | Per-channel mask, 1 blocks the channel |
| req_i | input | NUM_CH | Per-channel request |
| load_i | input | NUM_CH | Per-channel reprogram pulse |
| base_cnt_i | input | NUM_CH*CNT_W | Base counts, channel c at bits [c*CNT_W +: CNT_W] |
| base_addr_i | input | NUM_CH*CNT_W | Base addresses, same packing |
| mode_i | input | NUM_CH*8 | Mode bytes, channel c at bits [c*8 +: 8] |
| gnt_o | output | NUM_CH | One-hot grant |
| inc_o | output | 1 | One unit performed this cycle |
| addr_o | output | CNT_W+2 | Byte address of the unit |
| dir_down_o | output | 1 | Address runs downward |
| xfer_type_o | output | 2 | Transfer type of the granted channel |
| autoinit_o | output | 1 | Granted channel reloads after terminal count |
| tc_o | output | NUM_CH | Terminal-count strobe |
| tc_stat_o | output | NUM_CH | Sticky terminal-count status |

## Verification
Two events can land in the same cycle on one channel: a reprogram load, and a service that would bring the channel to terminal count. The bench keeps a channel one unit short of its length and pulses its load in the cycle it would have won. It then checks that the grant goes to the next eligible channel, that no terminal-count strobe appears and that the sticky status is cleared. Random load pulses mixed with random masks and requests repeat this collision many times, and a bench model predicts every output.

// File: rtl/dma_svc_pkg.sv
package dma_svc_pkg;
  localparam int MODE_W        = 8;
  localparam int MODE_DOWN_BIT = 5;
  localparam int MODE_AUTO_BIT = 4;
  localparam int MODE_TYPE_LSB = 2;

  typedef struct packed {
    logic       down;
    logic       reload;
    logic [1:0] xtype;
  } mode_fields_t;

  function automatic mode_fields_t decode_mode(input logic [MODE_W-1:0] m);
    mode_fields_t f;
    f.down   = m[MODE_DOWN_BIT];
    f.reload = m[MODE_AUTO_BIT];
    f.xtype  = m[MODE_TYPE_LSB +: 2];
    return f;
  endfunction
endpackage

// File: rtl/dma_chan_track.sv
module dma_chan_track #(
  parameter int CNT_W = 16,
  localparam int PW = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             svc_i,
  input  logic             shift_i,
  input  logic [CNT_W-1:0] base_cnt_i,
  input  logic             reload_i,
  output logic [PW-1:0]    pos_o,
  output logic             done_o,
  output logic             tc_hit_o,
  output logic             stat_o
);
  logic [PW-1:0] len;
  logic [PW-1:0] step;
  logic [PW-1:0] nxt;

  assign len      = (PW'(base_cnt_i) + PW'(1)) << shift_i;
  assign step     = shift_i ? PW'(2) : PW'(1);
  assign nxt      = pos_o + step;
  assign tc_hit_o = svc_i && (nxt == len);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_o  <= '0;
      done_o <= 1'b0;
      stat_o <= 1'b0;
    end else if (load_i) begin
      pos_o  <= '0;
      done_o <= 1'b0;
      stat_o <= 1'b0;
    end else if (svc_i) begin
      if (tc_hit_o) begin
        stat_o <= 1'b1;
        if (reload_i) begin
          pos_o <= '0;
        end else begin
          pos_o  <= nxt;
          done_o <= 1'b1;
        end
      end else begin
        pos_o <= nxt;
      end
    end
  end

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done_o && !load_i |=> done_o);
  // R7
  svc_not_done_chk: assert property (@(posedge clk) disable iff (rst)
    svc_i |-> !done_o);
  // R9
  load_clr_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (pos_o == '0) && !done_o && !stat_o);
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  elig_i,
  output logic [N-1:0]  gnt_o,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        gnt_o = '0;
        gnt_o[i] = 1'b1;
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int CNT_W = 16,
  localparam int AW = CNT_W + 2
) (
  input  logic [CNT_W-1:0] base_addr_i,
  input  logic [AW-1:0]    pos_i,
  input  logic             shift_i,
  input  logic             down_i,
  output logic [AW-1:0]    addr_o
);
  logic [AW-1:0] base_ext;
  assign base_ext = AW'(base_addr_i) << shift_i;
  assign addr_o   = down_i ? (base_ext - pos_i) : (base_ext + pos_i);
endmodule

// File: rtl/dma_svc_engine.sv
module dma_svc_engine #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int AW = CNT_W + 2,
  localparam int MW = dma_svc_pkg::MODE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ctl_dis_i,
  input  logic                    shift_i,
  input  logic [NUM_CH-1:0]       mask_i,
  input  logic [NUM_CH-1:0]       req_i,
  input  logic [NUM_CH-1:0]       load_i,
  input  logic [NUM_CH*CNT_W-1:0] base_cnt_i,
  input  logic [NUM_CH*CNT_W-1:0] base_addr_i,
  input  logic [NUM_CH*MW-1:0]    mode_i,
  output logic [NUM_CH-1:0]       gnt_o,
  output logic                    inc_o,
  output logic [AW-1:0]           addr_o,
  output logic                    dir_down_o,
  output logic [1:0]              xfer_type_o,
  output logic                    autoinit_o,
  output logic [NUM_CH-1:0]       tc_o,
  output logic [NUM_CH-1:0]       tc_stat_o
);
  import dma_svc_pkg::*;

  mode_fields_t       mf      [NUM_CH];
  logic [AW-1:0]      pos_a   [NUM_CH];
  logic [CNT_W-1:0]   baddr_a [NUM_CH];
  logic [NUM_CH-1:0]  elig;
  logic [NUM_CH-1:0]  done;
  logic [NUM_CH-1:0]  tc_hit;
  logic [NUM_CH-1:0]  pick_gnt;
  logic               pick_any;
  logic [IW-1:0]      pick_idx;
  logic [AW-1:0]      sel_addr;
  logic [NUM_CH*4-1:0] unused_mode_bits;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign mf[c]      = decode_mode(mode_i[c*MW +: MW]);
    assign baddr_a[c] = base_addr_i[c*CNT_W +: CNT_W];
    assign elig[c]    = ~ctl_dis_i & ~mask_i[c] & req_i[c] & ~done[c] & ~load_i[c];
    assign unused_mode_bits[c*4 +: 4] = {mode_i[c*MW+7 -: 2], mode_i[c*MW +: 2]};

    dma_chan_track #(.CNT_W(CNT_W)) u_trk (
      .clk        (clk),
      .rst        (rst),
      .load_i     (load_i[c]),
      .svc_i      (pick_gnt[c]),
      .shift_i    (shift_i),
      .base_cnt_i (base_cnt_i[c*CNT_W +: CNT_W]),
      .reload_i   (mf[c].reload),
      .pos_o      (pos_a[c]),
      .done_o     (done[c]),
      .tc_hit_o   (tc_hit[c]),
      .stat_o     (tc_stat_o[c])
    );
  end

  dma_prio_pick #(.N(NUM_CH)) u_pick (
    .elig_i (elig),
    .gnt_o  (pick_gnt),
    .any_o  (pick_any),
    .idx_o  (pick_idx)
  );

  dma_addr_gen #(.CNT_W(CNT_W)) u_addr (
    .base_addr_i (baddr_a[pick_idx]),
    .pos_i       (pos_a[pick_idx]),
    .shift_i     (shift_i),
    .down_i      (mf[pick_idx].down),
    .addr_o      (sel_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_o       <= '0;
      inc_o       <= 1'b0;
      addr_o      <= '0;
      dir_down_o  <= 1'b0;
      xfer_type_o <= '0;
      autoinit_o  <= 1'b0;
      tc_o        <= '0;
    end else begin
      gnt_o <= pick_gnt;
      inc_o <= pick_any;
      tc_o  <= tc_hit;
      if (pick_any) begin
        addr_o      <= sel_addr;
        dir_down_o  <= mf[pick_idx].down;
        xfer_type_o <= mf[pick_idx].xtype;
        autoinit_o  <= mf[pick_idx].reload;
      end else begin
        addr_o      <= '0;
        dir_down_o  <= 1'b0;
        xfer_type_o <= '0;
        autoinit_o  <= 1'b0;
      end
    end
  end

  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o));
  // R4
  tc_in_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    (tc_o & ~gnt_o) == '0);
  // R4
  tc_sets_stat_chk: assert property (@(posedge clk) disable iff (rst)
    (tc_o & ~tc_stat_o) == '0);
  // R8
  dis_block_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ctl_dis_i) |-> (gnt_o == '0));
  // R9
  load_no_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(load_i) & gnt_o) == '0);
endmodule

// File: tb/dma_svc_engine_bench.sv
module dma_svc_engine_bench;
  localparam int NC = 4;
  localparam int CW = 16;
  localparam int AW = CW + 2;
  localparam int unsigned AM = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dis = 1'b0;
  logic sh  = 1'b0;
  logic [NC-1:0] mask = '0, req = '0, load = '0;
  logic [CW-1:0] bc [NC];
  logic [CW-1:0] ba [NC];
  logic [7:0]    md [NC];
  logic [NC*CW-1:0] bc_f, ba_f;
  logic [NC*8-1:0]  md_f;

  logic [NC-1:0] gnt, tc, stat;
  logic inc, dir, autoi;
  logic [AW-1:0] addr;
  logic [1:0] xtype;

  int checks = 0;
  int fails  = 0;

  int unsigned m_pos [NC];
  bit m_done [NC];
  bit m_stat [NC];

  always #4 clk = ~clk;

  for (genvar c = 0; c < NC; c++) begin : g_pack
    assign bc_f[c*CW +: CW] = bc[c];
    assign ba_f[c*CW +: CW] = ba[c];
    assign md_f[c*8 +: 8]   = md[c];
  end

  dma_svc_engine #(.NUM_CH(NC), .CNT_W(CW)) u_dma_svc_engine (
    .clk(clk), .rst(rst), .ctl_dis_i(dis), .shift_i(sh),
    .mask_i(mask), .req_i(req), .load_i(load),
    .base_cnt_i(bc_f), .base_addr_i(ba_f), .mode_i(md_f),
    .gnt_o(gnt), .inc_o(inc), .addr_o(addr), .dir_down_o(dir),
    .xfer_type_o(xtype), .autoinit_o(autoi), .tc_o(tc), .tc_stat_o(stat)
  );

  task automatic chk(input int unsigned act, input int unsigned exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] stat_vec();
    logic [NC-1:0] v;
    for (int c = 0; c < NC; c++) v[c] = m_stat[c];
    return v;
  endfunction

  // One cycle: predict from the applied inputs, clock, then compare.
  task automatic tick(input string ph);
    int pick = -1;
    logic [NC-1:0] e_gnt = '0, e_tc = '0;
    int unsigned e_addr = 0, bae, len, np;
    bit e_inc = 0, e_dir = 0, e_auto = 0;
    logic [1:0] e_type = '0;
    for (int c = 0; c < NC; c++)
      if (pick < 0 && !dis && !mask[c] && req[c] && !m_done[c] && !load[c]) pick = c;
    if (pick >= 0) begin
      e_gnt[pick] = 1'b1;
      e_inc  = 1;
      e_dir  = md[pick][5];
      e_auto = md[pick][4];
      e_type = md[pick][3:2];
      bae    = (int'(ba[pick]) << sh) & AM;
      e_addr = e_dir ? ((bae - m_pos[pick]) & AM) : ((bae + m_pos[pick]) & AM);
      len    = (int'(bc[pick]) + 1) << sh;
      np     = (m_pos[pick] + (1 << sh)) & AM;
      if (np == len) begin
        e_tc[pick] = 1'b1;
        m_stat[pick] = 1;
        if (e_auto) m_pos[pick] = 0;
        else begin m_pos[pick] = np; m_done[pick] = 1; end
      end else m_pos[pick] = np;
    end
    for (int c = 0; c < NC; c++)
      if (load[c]) begin m_pos[c] = 0; m_done[c] = 0; m_stat[c] = 0; end
    @(posedge clk);
    @(negedge clk);
    chk(gnt,   e_gnt,  {ph, " R1 R2 grant"});
    chk(inc,   e_inc,  {ph, " R3 inc"});
    chk(tc,    e_tc,   {ph, " R4 tc strobe"});
    chk(stat,  stat_vec(), {ph, " R4 tc status"});
    chk(addr,  e_addr, {ph, " R5 address"});
    chk(dir,   e_dir,  {ph, " R5 direction"});
    chk(xtype, e_type, {ph, " R6 type"});
    chk(autoi, e_auto, {ph, " R6 reload flag"});
  endtask

  task automatic load_all();
    load = '1; tick("load"); load = '0;
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin
      bc[c] = '0; ba[c] = '0; md[c] = '0; m_pos[c] = 0; m_done[c] = 0; m_stat[c] = 0;
    end
    void'($urandom(32'h5eed_0042));
    mask = '0; req = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: outputs quiet during reset
    chk({gnt, inc, tc, stat, dir, autoi}, 0, "R10 reset outputs");
    chk(addr, 0, "R10 reset address");
    rst = 1'b0;
    req = '0;
    tick("R10 first cycle");

    // Priority: all channels request, base count 2, byte units
    for (int c = 0; c < NC; c++) begin bc[c] = 16'd2; ba[c] = 16'h1000 * (c + 1); md[c] = 8'h04; end
    load_all();
    req = '1;
    repeat (14) tick("R2 priority R7 stop");
    // R7: all done, still requesting, nobody granted
    chk(gnt, 0, "R7 finished channels idle");

    // Disable blocks service
    load_all();
    dis = 1'b1;
    repeat (3) tick("R8 disabled");
    dis = 1'b0;
    tick("R8 resumed");

    // Load collision: ch0 one unit short of length
    load_all();
    req = 4'b0011; mask = '0;
    tick("R9 prep"); tick("R9 prep");
    load = 4'b0001;
    tick("R9 load collision");
    chk(gnt, 4'b0010, "R9 grant moved to ch1");
    load = '0;
    tick("R9 after load");

    // Auto-reload, word units, downward addresses on ch2
    sh = 1'b1;
    md[2] = 8'h3C; bc[2] = 16'd1; ba[2] = 16'h0004;
    load_all();
    req = 4'b0100;
    repeat (9) tick("R7 R5 reload down");
    sh = 1'b0;

    // Random phases
    for (int p = 0; p < 3; p++) begin
      sh = p[0];
      for (int c = 0; c < NC; c++) begin
        bc[c] = 16'($urandom % 6);
        ba[c] = 16'($urandom);
        md[c] = 8'($urandom);
      end
      req = '0;
      load_all();
      for (int i = 0; i < 600; i++) begin
        mask = 4'($urandom);
        req  = 4'($urandom) | 4'($urandom);
        dis  = ($urandom % 16) == 0;
        load = (($urandom % 24) == 0) ? (4'b0001 << ($urandom % 4)) : 4'b0000;
        tick("random");
      end
      load = '0; dis = 1'b0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule